// File: doc/BRIEF.md
# Up/Down Auto-Reload Capture Timer

A counter of parameterized width, split into a low and a high half. It runs in one of three operating styles. In free-running capture style it counts up and rolls over to zero. A falling edge on the trigger pin can latch the running count into the companion capture/reload register. In auto-reload style the counter restarts from the capture/reload register when it rolls over. A trigger edge can also force that restart. If down-count is enabled, the synchronized trigger level chooses the direction instead. In baud style the counter advances on a state-time strobe, runs in auto-reload form and emits a one-cycle tick each time it wraps.

Counting events come from an internal tick strobe or from falling edges on an external count pin. Both pins pass through a two-stage synchronizer, so an edge acts three clock edges after the pin moves. A byte-wide write port loads the two count halves, the two reload halves, a control byte and a mode byte. The control byte also holds the two sticky flags, so software clears them by writing it. The block raises an interrupt request from those flags.

Top module: `tmr_updown_capture`

## Requirements
- R1: After reset the count, the reload value, the control byte and the mode byte are zero, both flags are clear, and irq_o, baud_tick_o and clkout_o are low.
- R2: Writes load the count halves (address 0 = low half, 1 = high half) and the reload halves (2 = low, 3 = high) from the low bits of wr_data_i. The write is visible on count_o/reload_o at the next edge and takes priority over counting in that cycle.
- R3: Control byte (address 4): bit0 run, bit1 external-count source, bit2 capture style, bit3 trigger enable, bit4 baud style, bit5 overflow flag, bit6 external flag. With run clear, count events are ignored. In capture style each event adds one, and all-ones rolls over to zero and sets the overflow flag.
- R4: In auto-reload style counting up, an event at all-ones loads the reload value and sets the overflow flag. Every other event adds one.
- R5: Mode byte (address 5): bit0 clock-out enable, bit1 down-count enable. With down-count enabled in auto-reload style, a low synchronized trigger level counts down and a high level counts up. Counting down, an event while the count equals the reload value loads all-ones and sets the overflow flag; any other event subtracts one.
- R6: With down-count active, every wrap in either direction toggles the external flag, and the external flag does not drive irq_o.
- R7: In capture style with trigger enable, an accepted trigger falling edge copies the count into the reload register and sets the external flag. With trigger enable clear, the edge changes neither.
- R8: In auto-reload style without down-count and with trigger enable, an accepted trigger falling edge loads the count from the reload register and sets the external flag.
- R9: With the external-count source selected, the count advances once per falling edge of the count pin, three clock edges after the pin falls. Rising edges and the internal tick do not count.
- R10: In baud style the counter advances on state_tick_i only, wraps from all-ones to the reload value, and pulses baud_tick_o high for one cycle after the wrap edge. The overflow flag is not set.
- R11: irq_o is high when the overflow flag is set, or when the external flag is set and down-count is not active.
- R12: Flags stay set until a control-byte write; such a write loads both flags from bits 5 and 6. A hardware set in the same cycle wins.
- R13: With clock-out enabled, clkout_o toggles on every counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | Internal count strobe |
| state_tick_i | input | 1 | State-time strobe used in baud style |
| cnt_pin_i | input | 1 | External count pin, counted on falling edges |
| trig_pin_i | input | 1 | External trigger pin (edge or direction level) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| count_o | output | CNT_W | Current count |
| reload_o | output | CNT_W | Capture/reload register |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ext_flag_o | output | 1 | Sticky external flag |
| irq_o | output | 1 | Interrupt request |
| baud_tick_o | output | 1 | One-cycle pulse per baud-style wrap |
| clkout_o | output | 1 | Toggles per wrap when enabled |

## Verification
The bench builds the block with CNT_W = 8, so each half is four bits wide and the whole count space is 256 values. At that width the bench can sweep every reload value through the up-count wrap and every reload value through the down-count underflow. It compares each step with its own arithmetic and tracks the toggling external flag. The small width also keeps the half-write path exercised, because each register write only covers four of the eight data bits.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W = 8;

  localparam logic [2:0] A_CNT_LO = 3'd0;
  localparam logic [2:0] A_CNT_HI = 3'd1;
  localparam logic [2:0] A_RLD_LO = 3'd2;
  localparam logic [2:0] A_RLD_HI = 3'd3;
  localparam logic [2:0] A_CTRL   = 3'd4;
  localparam logic [2:0] A_MODE   = 3'd5;

  localparam int C_RUN  = 0;
  localparam int C_EXT  = 1;
  localparam int C_CAP  = 2;
  localparam int C_TRG  = 3;
  localparam int C_BAUD = 4;
  localparam int C_OVF  = 5;
  localparam int C_XF   = 6;
  localparam int CTRL_USED = 7;

  localparam int M_OE = 0;
  localparam int M_DN = 1;

  typedef struct packed {
    logic baud;
    logic trig_en;
    logic cap;
    logic ext_src;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int   SYNC = 2,
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic prev_o
);
  logic [SYNC-1:0] sh_q;
  logic            prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= {SYNC{IDLE}};
      prev_q <= IDLE;
    end else begin
      sh_q   <= {sh_q[SYNC-2:0], pin_i};
      prev_q <= sh_q[SYNC-1];
    end
  end

  assign level_o = sh_q[SYNC-1];
  assign prev_o  = prev_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [2:0]           wr_addr_i,
  input  logic [CTRL_USED-1:0] wr_data_i,
  input  logic                 ovf_set_i,
  input  logic                 ext_set_i,
  input  logic                 ext_tgl_i,
  output ctrl_t                ctrl_o,
  output logic                 dn_en_o,
  output logic                 oe_o,
  output logic                 ovf_o,
  output logic                 ext_o,
  output logic                 irq_o
);
  ctrl_t ctrl_q;
  logic  dn_q, oe_q, ovf_q, ext_q;
  logic  ovf_d, ext_d;
  logic  ctrl_wr, mode_wr, dn_active;

  assign ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);
  assign mode_wr = wr_en_i && (wr_addr_i == A_MODE);

  always_comb begin
    ovf_d = ctrl_wr ? wr_data_i[C_OVF] : ovf_q;
    if (ovf_set_i) ovf_d = 1'b1;
    ext_d = ctrl_wr ? wr_data_i[C_XF] : ext_q;
    if (ext_set_i) ext_d = 1'b1;
    if (ext_tgl_i) ext_d = ~ext_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dn_q   <= 1'b0;
      oe_q   <= 1'b0;
      ovf_q  <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.run     <= wr_data_i[C_RUN];
        ctrl_q.ext_src <= wr_data_i[C_EXT];
        ctrl_q.cap     <= wr_data_i[C_CAP];
        ctrl_q.trig_en <= wr_data_i[C_TRG];
        ctrl_q.baud    <= wr_data_i[C_BAUD];
      end
      if (mode_wr) begin
        oe_q <= wr_data_i[M_OE];
        dn_q <= wr_data_i[M_DN];
      end
      ovf_q <= ovf_d;
      ext_q <= ext_d;
    end
  end

  assign dn_active = dn_q & ~ctrl_q.cap & ~ctrl_q.baud;
  assign ctrl_o    = ctrl_q;
  assign dn_en_o   = dn_q;
  assign oe_o      = oe_q;
  assign ovf_o     = ovf_q;
  assign ext_o     = ext_q;
  assign irq_o     = ovf_q | (ext_q & ~dn_active);

  // R12: the overflow flag only falls on a control write
  assert_ovf_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ctrl_wr) |=> ovf_q);

  // R6: a wrap in down-count style flips the external flag
  assert_ext_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_tgl_i && !ctrl_wr && !ext_set_i) |=> (ext_q != $past(ext_q)));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrl_t              ctrl_i,
  input  logic               dn_en_i,
  input  logic               oe_i,
  input  logic               tick_i,
  input  logic               state_tick_i,
  input  logic               cnt_fall_i,
  input  logic               trig_lvl_i,
  input  logic               trig_fall_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_addr_i,
  input  logic [CNT_W/2-1:0] wr_data_i,
  output logic [CNT_W-1:0]   count_o,
  output logic [CNT_W-1:0]   reload_o,
  output logic               ovf_set_o,
  output logic               ext_set_o,
  output logic               ext_tgl_o,
  output logic               baud_tick_o,
  output logic               clkout_o
);
  localparam int               HALF_W = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONES   = '1;

  function automatic logic [CNT_W-1:0] step(input logic up, input logic [CNT_W-1:0] c);
    return up ? c + CNT_W'(1) : c - CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] wrap_value(input logic up, input logic to_zero,
                                                  input logic [CNT_W-1:0] rld);
    if (!up)     return ONES;
    if (to_zero) return '0;
    return rld;
  endfunction

  logic [CNT_W-1:0] count_q, cnt_d, reload_q, rld_d;
  logic baud_q, clk_q;

  // named internal events
  logic cnt_wr, rld_wr, inc, dn_active, going_up, at_top, at_floor, cap_free;
  logic evt_trig_load, evt_wrap, evt_wrap_up, evt_wrap_dn, evt_capture;

  assign cnt_wr    = wr_en_i && (wr_addr_i == A_CNT_LO || wr_addr_i == A_CNT_HI);
  assign rld_wr    = wr_en_i && (wr_addr_i == A_RLD_LO || wr_addr_i == A_RLD_HI);
  assign cap_free  = ctrl_i.cap & ~ctrl_i.baud;
  assign dn_active = dn_en_i & ~ctrl_i.cap & ~ctrl_i.baud;
  assign going_up  = ~dn_active | trig_lvl_i;
  assign inc       = ctrl_i.run & (ctrl_i.baud ? state_tick_i
                                               : (ctrl_i.ext_src ? cnt_fall_i : tick_i));
  assign at_top    = (count_q == ONES);
  assign at_floor  = (count_q == reload_q);

  assign evt_trig_load = trig_fall_i & ctrl_i.trig_en & ~ctrl_i.cap & ~ctrl_i.baud
                         & ~dn_active & ~cnt_wr;
  assign evt_wrap      = inc & ~cnt_wr & ~evt_trig_load & (going_up ? at_top : at_floor);
  assign evt_wrap_up   = evt_wrap & going_up;
  assign evt_wrap_dn   = evt_wrap & ~going_up;
  assign evt_capture   = trig_fall_i & ctrl_i.trig_en & cap_free & ~rld_wr;

  always_comb begin
    cnt_d = count_q;
    if (cnt_wr) begin
      if (wr_addr_i == A_CNT_LO) cnt_d[HALF_W-1:0]     = wr_data_i;
      else                       cnt_d[CNT_W-1:HALF_W] = wr_data_i;
    end else if (evt_trig_load) begin
      cnt_d = reload_q;
    end else if (evt_wrap) begin
      cnt_d = wrap_value(going_up, cap_free, reload_q);
    end else if (inc) begin
      cnt_d = step(going_up, count_q);
    end
  end

  always_comb begin
    rld_d = reload_q;
    if (rld_wr) begin
      if (wr_addr_i == A_RLD_LO) rld_d[HALF_W-1:0]     = wr_data_i;
      else                       rld_d[CNT_W-1:HALF_W] = wr_data_i;
    end else if (evt_capture) begin
      rld_d = count_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      baud_q   <= 1'b0;
      clk_q    <= 1'b0;
    end else begin
      count_q  <= cnt_d;
      reload_q <= rld_d;
      baud_q   <= evt_wrap & ctrl_i.baud;
      if (evt_wrap && oe_i) clk_q <= ~clk_q;
    end
  end

  assign ovf_set_o   = evt_wrap & ~ctrl_i.baud;
  assign ext_set_o   = trig_fall_i & ctrl_i.trig_en & ~dn_active;
  assign ext_tgl_o   = evt_wrap & dn_active;
  assign count_o     = count_q;
  assign reload_o    = reload_q;
  assign baud_tick_o = baud_q;
  assign clkout_o    = clk_q;

  // R3: free-running capture style rolls over to zero
  assert_cap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wrap_up && cap_free) |=> (count_q == '0));

  // R4: reload style restarts from the reload register
  assert_up_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wrap_up && !cap_free) |=> (count_q == $past(reload_q)));

  // R5: underflow lands on all-ones
  assert_dn_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wrap_dn |=> (count_q == ONES));

  // R7: the capture event freezes the running count
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_capture |=> (reload_q == $past(count_q)));
endmodule

// File: rtl/tmr_updown_capture.sv
module tmr_updown_capture
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             state_tick_i,
  input  logic             cnt_pin_i,
  input  logic             trig_pin_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             ovf_flag_o,
  output logic             ext_flag_o,
  output logic             irq_o,
  output logic             baud_tick_o,
  output logic             clkout_o
);
  localparam int N_PINS  = 2;
  localparam int PIN_CNT = 0;
  localparam int PIN_TRG = 1;

  logic [N_PINS-1:0] pins, lvl, prev;
  logic cnt_fall, trig_fall;
  ctrl_t ctrl;
  logic dn_en, oe, ovf_set, ext_set, ext_tgl;

  assign pins = {trig_pin_i, cnt_pin_i};

  for (genvar g = 0; g < N_PINS; g++) begin : g_sync
    tmr_edge_sync #(.SYNC(SYNC), .IDLE(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (pins[g]),
      .level_o (lvl[g]),
      .prev_o  (prev[g])
    );
  end

  assign cnt_fall  = prev[PIN_CNT] & ~lvl[PIN_CNT];
  assign trig_fall = prev[PIN_TRG] & ~lvl[PIN_TRG];

  tmr_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i[CTRL_USED-1:0]),
    .ovf_set_i (ovf_set),
    .ext_set_i (ext_set),
    .ext_tgl_i (ext_tgl),
    .ctrl_o    (ctrl),
    .dn_en_o   (dn_en),
    .oe_o      (oe),
    .ovf_o     (ovf_flag_o),
    .ext_o     (ext_flag_o),
    .irq_o     (irq_o)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_i       (ctrl),
    .dn_en_i      (dn_en),
    .oe_i         (oe),
    .tick_i       (tick_i),
    .state_tick_i (state_tick_i),
    .cnt_fall_i   (cnt_fall),
    .trig_lvl_i   (lvl[PIN_TRG]),
    .trig_fall_i  (trig_fall),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i[CNT_W/2-1:0]),
    .count_o      (count_o),
    .reload_o     (reload_o),
    .ovf_set_o    (ovf_set),
    .ext_set_o    (ext_set),
    .ext_tgl_o    (ext_tgl),
    .baud_tick_o  (baud_tick_o),
    .clkout_o     (clkout_o)
  );

  // R9: an accepted count edge is a single-cycle event
  assert_one_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_fall |=> !cnt_fall);

  // R10: a baud tick never comes with a new overflow flag
  assert_baud_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick_o && !$past(ovf_flag_o) && !$past(wr_en_i)) |-> !ovf_flag_o);
endmodule

// File: tb/test_tmr_updown_capture.sv
module test_tmr_updown_capture;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 0, state_tick_i = 0, cnt_pin_i = 1, trig_pin_i = 1;
  logic wr_en_i = 0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [CW-1:0] count_o, reload_o;
  logic ovf_flag_o, ext_flag_o, irq_o, baud_tick_o, clkout_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_updown_capture #(.CNT_W(CW), .SYNC(2)) i_tmr_updown_capture (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .state_tick_i(state_tick_i),
    .cnt_pin_i(cnt_pin_i), .trig_pin_i(trig_pin_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .count_o(count_o),
    .reload_o(reload_o), .ovf_flag_o(ovf_flag_o), .ext_flag_o(ext_flag_o),
    .irq_o(irq_o), .baud_tick_o(baud_tick_o), .clkout_o(clkout_o));

  function automatic logic [7:0] m_up(input logic [7:0] c, input logic [7:0] r, input logic to_zero);
    if (c == 8'hFF) return to_zero ? 8'h00 : r;
    return c + 8'd1;
  endfunction

  function automatic logic [7:0] m_dn(input logic [7:0] c, input logic [7:0] r);
    if (c == r) return 8'hFF;
    return c - 8'd1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic set_cnt(input logic [7:0] v);
    wr(3'd0, {4'h0, v[3:0]});
    wr(3'd1, {4'h0, v[7:4]});
  endtask

  task automatic set_rld(input logic [7:0] v);
    wr(3'd2, {4'h0, v[3:0]});
    wr(3'd3, {4'h0, v[7:4]});
  endtask

  task automatic tick1();
    tick_i = 1; @(negedge clk); tick_i = 0;
  endtask

  task automatic st1();
    state_tick_i = 1; @(negedge clk); state_tick_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-R act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] c, cv;
    logic eo, ov;
    idle(2);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 reload", reload_o, 0);
    chk("R1 ovf", ovf_flag_o, 0);
    chk("R1 ext", ext_flag_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 baud", baud_tick_o, 0);
    chk("R1 clkout", clkout_o, 0);
    tick1();
    chk("R1 idle after reset", count_o, 0);

    // R2 half writes
    set_cnt(8'hA5);
    set_rld(8'h3C);
    chk("R2 count", count_o, 8'hA5);
    chk("R2 reload", reload_o, 8'h3C);

    // R3 run clear ignores ticks, capture style rolls to zero
    tick1();
    chk("R3 stopped", count_o, 8'hA5);
    wr(3'd4, 8'h05);
    set_cnt(8'hFD);
    c = 8'hFD;
    for (int i = 0; i < 4; i++) begin
      tick1();
      c = m_up(c, 8'h3C, 1'b1);
      chk("R3 capture count", count_o, c);
    end
    chk("R3 ovf", ovf_flag_o, 1);

    // R4 sweep over every reload value, R12 flag clear
    wr(3'd4, 8'h01);
    for (int r = 0; r < 256; r++) begin
      set_rld(r[7:0]);
      set_cnt(8'hFE);
      tick1();
      chk("R4 top", count_o, 8'hFF);
      chk("R12 no set before wrap", ovf_flag_o, 0);
      tick1();
      chk("R4 reload", count_o, r[7:0]);
      chk("R4 ovf", ovf_flag_o, 1);
      tick1();
      chk("R12 sticky", ovf_flag_o, 1);
      wr(3'd4, 8'h01);
      chk("R12 cleared", ovf_flag_o, 0);
    end

    // R5 R6 down-count sweep with trigger low
    wr(3'd5, 8'h02);
    trig_pin_i = 0;
    idle(4);
    for (int r = 0; r < 256; r++) begin
      set_rld(r[7:0]);
      set_cnt(r[7:0] + 8'd2);
      wr(3'd4, 8'h01);
      c = r[7:0] + 8'd2; eo = 0; ov = 0;
      for (int k = 0; k < 3; k++) begin
        tick1();
        if (c == r[7:0]) begin ov = 1; eo = ~eo; end
        c = m_dn(c, r[7:0]);
        chk("R5 down count", count_o, c);
        chk("R6 ext toggle", ext_flag_o, eo);
      end
      chk("R5 ovf", ovf_flag_o, ov);
      chk("R6 irq ovf only", irq_o, ov);
    end
    wr(3'd4, 8'h41);
    chk("R6 ext masked irq", irq_o, 0);

    // R5 trigger high counts up in down-count mode
    trig_pin_i = 1;
    idle(4);
    set_rld(8'h10);
    set_cnt(8'hFE);
    wr(3'd4, 8'h01);
    tick1();
    chk("R5 up dir", count_o, 8'hFF);
    tick1();
    chk("R5 up reload", count_o, 8'h10);
    chk("R6 up toggle", ext_flag_o, 1);

    // R11 external flag drives irq outside down-count
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h41);
    chk("R11 ext irq", irq_o, 1);
    wr(3'd4, 8'h21);
    chk("R11 ovf irq", irq_o, 1);
    wr(3'd4, 8'h01);
    chk("R11 quiet", irq_o, 0);

    // R7 capture on trigger fall
    wr(3'd4, 8'h0D);
    set_cnt(8'h5A);
    trig_pin_i = 0;
    idle(3);
    chk("R7 captured", reload_o, 8'h5A);
    chk("R7 ext", ext_flag_o, 1);
    trig_pin_i = 1;
    idle(3);
    wr(3'd4, 8'h05);
    set_cnt(8'h33);
    trig_pin_i = 0;
    idle(3);
    chk("R7 disabled reload", reload_o, 8'h5A);
    chk("R7 disabled ext", ext_flag_o, 0);
    trig_pin_i = 1;
    idle(3);

    // R8 trigger forced reload
    wr(3'd4, 8'h09);
    set_rld(8'h77);
    set_cnt(8'h20);
    trig_pin_i = 0;
    idle(3);
    chk("R8 forced", count_o, 8'h77);
    chk("R8 ext", ext_flag_o, 1);
    trig_pin_i = 1;
    idle(3);

    // R9 external count pin
    wr(3'd4, 8'h03);
    set_cnt(8'h40);
    tick1();
    chk("R9 tick ignored", count_o, 8'h40);
    cv = 8'h40;
    for (int k = 1; k <= 5; k++) begin
      cnt_pin_i = 0;
      idle(2);
      chk("R9 latency", count_o, cv);
      idle(1);
      cv = cv + 8'd1;
      chk("R9 fall counted", count_o, cv);
      cnt_pin_i = 1;
      idle(3);
      chk("R9 rise ignored", count_o, cv);
    end

    // R10 baud style
    wr(3'd4, 8'h11);
    set_rld(8'hF0);
    set_cnt(8'hFE);
    tick1();
    chk("R10 tick ignored", count_o, 8'hFE);
    st1();
    chk("R10 step", count_o, 8'hFF);
    chk("R10 no pulse", baud_tick_o, 0);
    st1();
    chk("R10 wrap", count_o, 8'hF0);
    chk("R10 pulse", baud_tick_o, 1);
    chk("R10 no ovf", ovf_flag_o, 0);
    idle(1);
    chk("R10 pulse ends", baud_tick_o, 0);

    // R13 clock output toggles on wrap
    wr(3'd4, 8'h01);
    wr(3'd5, 8'h01);
    chk("R13 start", clkout_o, 0);
    set_cnt(8'hFF);
    tick1();
    chk("R13 toggled", clkout_o, 1);
    tick1();
    chk("R13 held", clkout_o, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule